// File: doc/BRIEF.md
# LIN Bit-Time Control Register

This block holds the bit-time setting of a LIN/UART serial controller. The setting has two parts. The first is a divisor that gives the number of samples taken per serial bit. The second is a flag that turns off automatic resynchronization. Software writes the register only while the controller is switched off. Each write chooses one of two modes:

- **Automatic timing.** The flag is clear. The divisor is forced to its default, and resynchronization is enabled.
- **Manual timing.** The flag is set. The written divisor is loaded, raised to a floor if it is too small, and resynchronization is disabled.

In automatic timing on a slave node, the header's sync-field measurement may replace the divisor. That measured value applies only to the current frame. The divisor returns to the default when the response ends. A node acting as master never resynchronizes.

The block outputs the active divisor to the baud-rate generator. It also outputs a resync-enable signal to the sync-field measurement logic.

Top module: `lin_bittime_reg`

## Requirements
- R1: While reset is asserted, and after it is released, the divisor output is 32 and the stored disable flag is 0. As a result, `resync_en` is high whenever `is_master` is low.
- R2: An accepted write with `wr_dis`=0 sets the divisor to 32 and clears the flag, so resync is enabled. The value on `wr_div` is disregarded. A write is accepted when `wr_en`=1 and `ctrl_en`=0.
- R3: An accepted write with `wr_dis`=1 loads `wr_div` as the divisor and sets the flag, so `resync_en` is 0.
- R4: A manual divisor below 8 is stored as 8. Values from 8 up to 63 are stored unchanged.
- R5: A write with `ctrl_en`=1 has no effect on the divisor or on the flag.
- R6: A resync update loads `sync_div` only when all of the following hold: `sync_vld`=1, the flag is 0, and `is_master`=0. The loaded value is raised to 8 if it is smaller.
- R7: A `rsp_end` pulse while the flag is 0 returns the divisor to 32. While the flag is 1, a `rsp_end` pulse leaves the manual divisor unchanged.
- R8: While `is_master`=1, `resync_en` is 0 and the divisor never takes a sync measurement.
- R9: When events fall in the same cycle, they take effect in this order: an accepted write first, then `rsp_end`, then a resync update.
- R10: All updates become visible on the outputs one clock edge after the cycle in which they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enabled; writes are blocked while high |
| is_master | input | 1 | Node operates as master |
| wr_en | input | 1 | Register write strobe |
| wr_dis | input | 1 | Written resync-disable flag |
| wr_div | input | 6 | Written divisor |
| rsp_end | input | 1 | End-of-response strobe |
| sync_vld | input | 1 | Sync-field measurement valid |
| sync_div | input | 6 | Measured divisor from the sync field |
| bit_div | output | 6 | Active samples-per-bit divisor |
| resync_en | output | 1 | Resynchronization permitted |

## Verification
Two pairs of functions can collide in a single cycle:

- **End of response and sync measurement.** When `rsp_end` and an eligible `sync_vld` coincide, the restore to 32 must win.
- **Write and resync.** When a write arrives while ctrl_en is low and a sync measurement is present, the write must win.

Random stimulus with independent strobe probabilities produces both kinds of collision many times. Directed cases force each pairing once. The bench model applies the priority order explicitly and compares the divisor and resync-enable one edge later.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  localparam int unsigned LBT_DIV_W = 6;

  // Raise a divisor to a floor value
  function automatic logic [LBT_DIV_W-1:0] lbt_floor(
    input logic [LBT_DIV_W-1:0] val,
    input logic [LBT_DIV_W-1:0] lim
  );
    return (val < lim) ? lim : val;
  endfunction
endpackage

// File: rtl/lbt_wr_qual.sv
module lbt_wr_qual
  import lbt_pkg::*;
#(
  parameter int unsigned DIV_W   = LBT_DIV_W,
  parameter int unsigned DIV_DEF = 32,
  parameter int unsigned DIV_MIN = 8
) (
  input  logic             wr_en,
  input  logic             ctrl_en,
  input  logic             wr_dis,
  input  logic [DIV_W-1:0] wr_div,
  output logic             wr_take,
  output logic             wr_flag,
  output logic [DIV_W-1:0] wr_val
);
  localparam logic [DIV_W-1:0] DEF_V = DIV_W'(DIV_DEF);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(DIV_MIN);

  always_comb begin
    wr_take = wr_en & ~ctrl_en;
    wr_flag = wr_dis;
    wr_val  = wr_dis ? lbt_floor(wr_div, MIN_V) : DEF_V;
  end
endmodule

// File: rtl/lbt_resync_gate.sv
module lbt_resync_gate
  import lbt_pkg::*;
#(
  parameter int unsigned DIV_W   = LBT_DIV_W,
  parameter int unsigned DIV_MIN = 8
) (
  input  logic             dis_q,
  input  logic             is_master,
  input  logic             sync_vld,
  input  logic [DIV_W-1:0] sync_div,
  output logic             rs_allow,
  output logic             rs_take,
  output logic [DIV_W-1:0] rs_val
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(DIV_MIN);

  always_comb begin
    rs_allow = ~dis_q & ~is_master;
    rs_take  = rs_allow & sync_vld;
    rs_val   = lbt_floor(sync_div, MIN_V);
  end
endmodule

// File: rtl/lin_bittime_reg.sv
module lin_bittime_reg
  import lbt_pkg::*;
#(
  parameter int unsigned DIV_W   = LBT_DIV_W,
  parameter int unsigned DIV_DEF = 32,
  parameter int unsigned DIV_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             is_master,
  input  logic             wr_en,
  input  logic             wr_dis,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             rsp_end,
  input  logic             sync_vld,
  input  logic [DIV_W-1:0] sync_div,
  output logic [DIV_W-1:0] bit_div,
  output logic             resync_en
);
  localparam logic [DIV_W-1:0] DEF_V = DIV_W'(DIV_DEF);

  logic             div_ce, dis_ce;
  logic [DIV_W-1:0] div_q, div_d;
  logic             dis_q, dis_d;
  logic             wr_take, wr_flag, rs_allow, rs_take;
  logic [DIV_W-1:0] wr_val, rs_val;

  lbt_wr_qual #(.DIV_W(DIV_W), .DIV_DEF(DIV_DEF), .DIV_MIN(DIV_MIN)) u_wr (
    .wr_en   (wr_en),
    .ctrl_en (ctrl_en),
    .wr_dis  (wr_dis),
    .wr_div  (wr_div),
    .wr_take (wr_take),
    .wr_flag (wr_flag),
    .wr_val  (wr_val)
  );

  lbt_resync_gate #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_rs (
    .dis_q     (dis_q),
    .is_master (is_master),
    .sync_vld  (sync_vld),
    .sync_div  (sync_div),
    .rs_allow  (rs_allow),
    .rs_take   (rs_take),
    .rs_val    (rs_val)
  );

  // Next state: write, then end of response, then resync
  always_comb begin
    div_ce = 1'b0;
    dis_ce = 1'b0;
    div_d  = div_q;
    dis_d  = dis_q;
    if (wr_take) begin
      div_ce = 1'b1;
      dis_ce = 1'b1;
      div_d  = wr_val;
      dis_d  = wr_flag;
    end else if (rsp_end && !dis_q) begin
      div_ce = 1'b1;
      div_d  = DEF_V;
    end else if (rs_take) begin
      div_ce = 1'b1;
      div_d  = rs_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DEF_V;
    end else if (div_ce) begin
      div_q <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b0;
    end else if (dis_ce) begin
      dis_q <= dis_d;
    end
  end

  assign bit_div   = div_q;
  assign resync_en = rs_allow;
endmodule

// File: rtl/lin_bittime_reg_chk.sv
module lin_bittime_reg_chk #(
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned DIV_DEF = 32,
  parameter int unsigned DIV_MIN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_en,
  input logic             is_master,
  input logic             wr_en,
  input logic             wr_dis,
  input logic             rsp_end,
  input logic             sync_vld,
  input logic [DIV_W-1:0] bit_div,
  input logic             resync_en
);
  // R4
  div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_div >= DIV_W'(DIV_MIN));

  // R8
  master_no_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> !resync_en);

  // R2
  auto_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_en && !wr_dis) |=> (bit_div == DIV_W'(DIV_DEF)));

  // R3
  manual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_en && wr_dis) |=> !resync_en);

  // R5
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_en && !sync_vld && !rsp_end) |=> $stable(bit_div));

  // R7
  rsp_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_end && resync_en && !(wr_en && !ctrl_en)) |=> (bit_div == DIV_W'(DIV_DEF)));
endmodule

bind lin_bittime_reg lin_bittime_reg_chk #(
  .DIV_W(DIV_W), .DIV_DEF(DIV_DEF), .DIV_MIN(DIV_MIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_en   (ctrl_en),
  .is_master (is_master),
  .wr_en     (wr_en),
  .wr_dis    (wr_dis),
  .rsp_end   (rsp_end),
  .sync_vld  (sync_vld),
  .bit_div   (bit_div),
  .resync_en (resync_en)
);

// File: tb/lin_bittime_reg_bench.sv
module lin_bittime_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_en, is_master, wr_en, wr_dis, rsp_end, sync_vld;
  logic [5:0] wr_div, sync_div;
  logic [5:0] bit_div;
  logic       resync_en;

  int n_chk = 0;
  int n_bad = 0;

  // Model state
  logic [5:0] m_div;
  logic       m_dis;

  always #2.5 clk = ~clk;

  lin_bittime_reg u_lin_bittime_reg (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .is_master(is_master),
    .wr_en(wr_en), .wr_dis(wr_dis), .wr_div(wr_div), .rsp_end(rsp_end),
    .sync_vld(sync_vld), .sync_div(sync_div), .bit_div(bit_div),
    .resync_en(resync_en)
  );

  function automatic logic [5:0] flr(input logic [5:0] v);
    return (v < 6'd8) ? 6'd8 : v;
  endfunction

  function automatic string tag_of();
    if (wr_en && !ctrl_en) return wr_dis ? ((wr_div < 8) ? "R4" : "R3") : "R2";
    if (wr_en && ctrl_en) return "R5";
    if (rsp_end && sync_vld) return "R9";
    if (rsp_end) return "R7";
    if (sync_vld && is_master) return "R8";
    if (sync_vld) return "R6";
    return "R10";
  endfunction

  task automatic check(input string tag);
    logic exp_rs;
    exp_rs = !m_dis && !is_master;
    n_chk++;
    if (bit_div !== m_div || resync_en !== exp_rs) begin
      n_bad++;
      $display("FAIL %s: bit_div=%0d resync_en=%0b expected %0d/%0b",
               tag, bit_div, resync_en, m_div, exp_rs);
    end
  endtask

  // Apply one cycle of inputs (called at negedge), update model, check after the edge
  task automatic apply(input logic ce, input logic ms, input logic we, input logic wd,
                       input logic [5:0] wv, input logic re, input logic sv,
                       input logic [5:0] sd);
    string t;
    ctrl_en = ce; is_master = ms; wr_en = we; wr_dis = wd; wr_div = wv;
    rsp_end = re; sync_vld = sv; sync_div = sd;
    t = tag_of();
    if (we && !ce) begin
      m_dis = wd;
      m_div = wd ? flr(wv) : 6'd32;
    end else if (re && !m_dis) begin
      m_div = 6'd32;
    end else if (sv && !m_dis && !ms) begin
      m_div = flr(sd);
    end
    @(posedge clk);
    #1;
    check(t);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #500000;
    n_bad++;
    $display("FAIL watchdog: timeout expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    ctrl_en = 0; is_master = 0; wr_en = 0; wr_dis = 0; wr_div = 0;
    rsp_end = 0; sync_vld = 0; sync_div = 0;
    m_div = 6'd32; m_dis = 1'b0;
    #12;
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // Directed corner cases
    apply(0, 0, 1, 1, 6'd3,  0, 0, 0);   // R4 low value raised
    apply(0, 0, 1, 1, 6'd8,  0, 0, 0);   // R4 boundary
    apply(0, 0, 0, 0, 0,     1, 0, 0);   // R7 manual kept
    apply(0, 0, 1, 1, 6'd63, 0, 1, 6'd20); // R3
    apply(1, 0, 1, 0, 6'd9,  0, 0, 0);   // R5 blocked
    apply(0, 0, 1, 0, 6'd50, 0, 0, 0);   // R2
    apply(1, 0, 0, 0, 0,     0, 1, 6'd2); // R6 floor
    apply(1, 0, 0, 0, 0,     1, 1, 6'd40); // R9 end wins
    apply(1, 0, 0, 0, 0,     0, 1, 6'd40); // R6
    apply(0, 0, 1, 0, 0,     0, 1, 6'd17); // R9 write wins
    apply(1, 1, 0, 0, 0,     0, 1, 6'd12); // R8
    apply(1, 0, 0, 0, 0,     1, 0, 0);   // R7

    // Random stimulus
    for (int i = 0; i < 4000; i++) begin
      apply(($urandom % 3) != 0, ($urandom % 4) == 0, ($urandom % 6) == 0,
            $urandom % 2, 6'($urandom), ($urandom % 5) == 0,
            ($urandom % 3) == 0, 6'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule